// File: doc/BRIEF.md
# NEC Infrared Frame Decoder

This block turns a stream of measured infrared pulse widths into decoded remote-control frames. A capture unit upstream reports each interval on the line as a microsecond count together with the line level that interval belongs to (0 for a burst/low interval, 1 for a space/high interval). The decoder checks every interval against a fixed tolerance window. It walks through the leader, the 32 payload bits and the trailing stop burst, and then produces the 16-bit user code and the 8-bit data byte.

After a good frame the decoder stays in a sequence state. There it watches for the stop burst, the inter-frame gap and the short repeat leader that a held key produces, and it emits a repeat strobe for each repeat it sees. Any interval that misses its window throws away the partial frame and returns the decoder to idle, so a noisy line cannot produce any output.

Top module: `nec_ir_decoder`

## Requirements
- R1: While reset is held and directly after it, `frame_vld` and `rpt_vld` are 0 and `user_code` and `data_byte` are 0.
- R2: A frame starts only with a low interval of 8000 to 10000 us followed by a high interval of 4000 to 5000 us. Both bounds are inclusive. A leader interval outside its window produces no frame.
- R3: The low interval of every payload bit must lie within 390 to 730 us inclusive. Otherwise the partial frame is dropped with no output.
- R4: A payload bit's high interval of 390 to 730 us is a 0 and one of 1300 to 2000 us is a 1, bounds inclusive. Any other high interval drops the frame.
- R5: Bits arrive least significant first. Received bits 0 to 15 form `user_code` with bit 0 as its LSB. Bits 16 to 23 form `data_byte` and bits 24 to 31 form its inverted check copy.
- R6: A correct frame raises `frame_vld` for exactly one clock cycle, on the second clock edge after the 32nd bit's high interval is accepted. `user_code` and `data_byte` update in that same cycle.
- R7: A frame whose check byte is not the bitwise inverse of the data byte gives no `frame_vld`, and `user_code` and `data_byte` keep their previous values.
- R8: After a correct frame, a repeat is recognised from four intervals in order: a stop low of 390 to 730 us, a high gap of either 30000 to 55000 us or 95000 to 98000 us, a low of 8000 to 10000 us, and a high of 2000 to 2500 us. The repeat raises `rpt_vld` for one cycle, and further repeats may follow the same pattern.
- R9: A repeat pattern received when no correct frame precedes it, starting from idle, raises no `rpt_vld`.
- R10: In the sequence state, a gap outside both gap windows returns the decoder to idle. Later repeat patterns are then ignored until a new correct frame is received.
- R11: In the sequence state, a leader low followed by a 4000 to 5000 us high begins a new full frame without first passing through idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_vld | input | 1 | One-cycle strobe: a measured interval is presented |
| pulse_lvl | input | 1 | Line level of the interval (0 low, 1 high) |
| pulse_us | input | DUR_W (17) | Interval length in microseconds |
| frame_vld | output | 1 | One-cycle strobe for a correct frame |
| user_code | output | 16 | User code of the last correct frame |
| data_byte | output | 8 | Data byte of the last correct frame |
| rpt_vld | output | 1 | One-cycle strobe for a recognised repeat |

## Verification
The assertions assume that `pulse_vld` is a single-cycle strobe and that two strobes are at least three clock cycles apart. A real capture unit never reports intervals shorter than hundreds of microseconds, so the spacing holds in practice, and the frame check needs the idle cycle after the last bit. The stimulus tasks always raise `pulse_vld` for one cycle and then hold it low for three. Durations are kept below the 17-bit limit, so no count wraps into a window. Between table frames the bench sends a long high interval that matches no window, which parks the decoder in idle.

// File: rtl/nec_pkg.sv
package nec_pkg;

    localparam int UC_W   = 16;
    localparam int DAT_W  = 8;
    localparam int NBITS  = UC_W + 2 * DAT_W;

    // tolerance windows, inclusive, microseconds
    localparam int NWIN      = 7;
    localparam int W_LEAD_LO = 0;
    localparam int W_LEAD_HI = 1;
    localparam int W_RPT_HI  = 2;
    localparam int W_SHORT   = 3;
    localparam int W_LONG    = 4;
    localparam int W_GAP_A   = 5;
    localparam int W_GAP_B   = 6;

    localparam int unsigned WIN_LO [NWIN] = '{8000, 4000, 2000, 390, 1300, 30000, 95000};
    localparam int unsigned WIN_HI [NWIN] = '{10000, 5000, 2500, 730, 2000, 55000, 98000};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRELOAD,
        ST_USER,
        ST_DATA,
        ST_SEQ
    } nec_state_e;

    typedef enum logic [1:0] {
        SQ_STOP,
        SQ_GAP,
        SQ_LEAD,
        SQ_HEAD
    } nec_seq_e;

    function automatic logic chk_ok(input logic [DAT_W-1:0] dat, input logic [DAT_W-1:0] inv);
        return (dat == ~inv);
    endfunction

endpackage

// File: rtl/nec_win_classify.sv
module nec_win_classify
    import nec_pkg::*;
#(
    parameter int DUR_W = 17
) (
    input  logic [DUR_W-1:0] dur,
    output logic [NWIN-1:0]  hit
);

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        assign hit[g] = (32'(dur) >= WIN_LO[g]) && (32'(dur) <= WIN_HI[g]);
    end

endmodule

// File: rtl/nec_bit_collect.sv
module nec_bit_collect #(
    parameter int NB = 32,
    localparam int CW = $clog2(NB + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [NB-1:0] word,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            word <= '0;
            cnt  <= '0;
        end else if (shift_en) begin
            word <= {bit_in, word[NB-1:1]};
            cnt  <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/nec_seq_fsm.sv
module nec_seq_fsm
    import nec_pkg::*;
#(
    localparam int CW = $clog2(NBITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_vld,
    input  logic              pulse_lvl,
    input  logic [NWIN-1:0]   hit,
    input  logic [NBITS-1:0]  word,
    input  logic [CW-1:0]     cnt,
    output logic              shift_en,
    output logic              shift_bit,
    output logic              clr,
    output logic              frame_vld,
    output logic              rpt_vld,
    output logic [UC_W-1:0]   user_code,
    output logic [DAT_W-1:0]  data_byte,
    output nec_state_e        state
);

    nec_state_e st_n;
    nec_seq_e   sq, sq_n;
    logic       exp_hi, exp_hi_n;
    logic       fv_n, rv_n;

    logic [DAT_W-1:0] dat_f, inv_f;
    assign dat_f = word[UC_W +: DAT_W];
    assign inv_f = word[UC_W+DAT_W +: DAT_W];

    always_comb begin
        st_n      = state;
        sq_n      = sq;
        exp_hi_n  = exp_hi;
        shift_en  = 1'b0;
        shift_bit = 1'b0;
        clr       = 1'b0;
        fv_n      = 1'b0;
        rv_n      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (pulse_vld && !pulse_lvl && hit[W_LEAD_LO]) st_n = ST_PRELOAD;
            end
            ST_PRELOAD: begin
                if (pulse_vld) begin
                    if (pulse_lvl && hit[W_LEAD_HI]) begin
                        st_n     = ST_USER;
                        clr      = 1'b1;
                        exp_hi_n = 1'b0;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end
            end
            ST_USER, ST_DATA: begin
                if (state == ST_DATA && cnt == CW'(NBITS)) begin
                    if (chk_ok(dat_f, inv_f)) begin
                        fv_n = 1'b1;
                        st_n = ST_SEQ;
                        sq_n = SQ_STOP;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end else if (pulse_vld) begin
                    if (!exp_hi) begin
                        if (!pulse_lvl && hit[W_SHORT]) exp_hi_n = 1'b1;
                        else                            st_n     = ST_IDLE;
                    end else if (pulse_lvl && (hit[W_SHORT] || hit[W_LONG])) begin
                        shift_en  = 1'b1;
                        shift_bit = hit[W_LONG];
                        exp_hi_n  = 1'b0;
                        if (state == ST_USER && cnt == CW'(UC_W - 1)) st_n = ST_DATA;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end
            end
            ST_SEQ: begin
                if (pulse_vld) begin
                    unique case (sq)
                        SQ_STOP: if (!pulse_lvl && hit[W_SHORT]) sq_n = SQ_GAP;
                                 else st_n = ST_IDLE;
                        SQ_GAP:  if (pulse_lvl && (hit[W_GAP_A] || hit[W_GAP_B])) sq_n = SQ_LEAD;
                                 else st_n = ST_IDLE;
                        SQ_LEAD: if (!pulse_lvl && hit[W_LEAD_LO]) sq_n = SQ_HEAD;
                                 else st_n = ST_IDLE;
                        SQ_HEAD: begin
                            if (pulse_lvl && hit[W_RPT_HI]) begin
                                rv_n = 1'b1;
                                sq_n = SQ_STOP;
                            end else if (pulse_lvl && hit[W_LEAD_HI]) begin
                                st_n     = ST_USER;
                                clr      = 1'b1;
                                exp_hi_n = 1'b0;
                            end else begin
                                st_n = ST_IDLE;
                            end
                        end
                        default: st_n = ST_IDLE;
                    endcase
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sq        <= SQ_STOP;
            exp_hi    <= 1'b0;
            frame_vld <= 1'b0;
            rpt_vld   <= 1'b0;
            user_code <= '0;
            data_byte <= '0;
        end else begin
            state     <= st_n;
            sq        <= sq_n;
            exp_hi    <= exp_hi_n;
            frame_vld <= fv_n;
            rpt_vld   <= rv_n;
            if (fv_n) begin
                user_code <= word[UC_W-1:0];
                data_byte <= dat_f;
            end
        end
    end

endmodule

// File: rtl/nec_ir_decoder.sv
module nec_ir_decoder
    import nec_pkg::*;
#(
    parameter int DUR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_vld,
    input  logic              pulse_lvl,
    input  logic [DUR_W-1:0]  pulse_us,
    output logic              frame_vld,
    output logic [UC_W-1:0]   user_code,
    output logic [DAT_W-1:0]  data_byte,
    output logic              rpt_vld
);

    localparam int CW = $clog2(NBITS + 1);

    logic [NWIN-1:0]  hit;
    logic [NBITS-1:0] word;
    logic [CW-1:0]    cnt;
    logic             shift_en, shift_bit, clr;
    nec_state_e       state;

    nec_win_classify #(.DUR_W(DUR_W)) i_cls (
        .dur (pulse_us),
        .hit (hit)
    );

    nec_bit_collect #(.NB(NBITS)) i_col (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .shift_en (shift_en),
        .bit_in   (shift_bit),
        .word     (word),
        .cnt      (cnt)
    );

    nec_seq_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .pulse_vld (pulse_vld),
        .pulse_lvl (pulse_lvl),
        .hit       (hit),
        .word      (word),
        .cnt       (cnt),
        .shift_en  (shift_en),
        .shift_bit (shift_bit),
        .clr       (clr),
        .frame_vld (frame_vld),
        .rpt_vld   (rpt_vld),
        .user_code (user_code),
        .data_byte (data_byte),
        .state     (state)
    );

endmodule

// File: rtl/nec_ir_decoder_chk.sv
module nec_ir_decoder_chk
    import nec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_vld,
    input logic              rpt_vld,
    input logic [UC_W-1:0]   user_code,
    input logic [DAT_W-1:0]  data_byte,
    input nec_state_e        state
);

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(frame_vld && rpt_vld));

    p_frame_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        frame_vld |=> !frame_vld);

    p_frame_origin_r6: assert property (@(posedge clk) disable iff (rst)
        frame_vld |-> ($past(state) == ST_DATA) && (state == ST_SEQ));

    p_rpt_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rpt_vld |=> !rpt_vld);

    p_rpt_in_seq_r9: assert property (@(posedge clk) disable iff (rst)
        rpt_vld |-> ($past(state) == ST_SEQ));

    p_code_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !($stable(user_code) && $stable(data_byte)) |-> frame_vld);

endmodule

bind nec_ir_decoder nec_ir_decoder_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_vld (frame_vld),
    .rpt_vld   (rpt_vld),
    .user_code (user_code),
    .data_byte (data_byte),
    .state     (state)
);

// File: tb/test_nec_ir_decoder.sv
module test_nec_ir_decoder;

    localparam int DUR_W = 17;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pulse_vld = 1'b0;
    logic             pulse_lvl = 1'b0;
    logic [DUR_W-1:0] pulse_us = '0;
    logic             frame_vld, rpt_vld;
    logic [15:0]      user_code;
    logic [7:0]       data_byte;

    always #10 clk = ~clk;

    nec_ir_decoder #(.DUR_W(DUR_W)) i_nec_ir_decoder (
        .clk       (clk),
        .rst       (rst),
        .pulse_vld (pulse_vld),
        .pulse_lvl (pulse_lvl),
        .pulse_us  (pulse_us),
        .frame_vld (frame_vld),
        .user_code (user_code),
        .data_byte (data_byte),
        .rpt_vld   (rpt_vld)
    );

    int total = 0;
    int bad   = 0;
    int nf = 0;
    int nr = 0;
    bit finished = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (frame_vld) nf++;
            if (rpt_vld)   nr++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic lvl, input int us);
        @(negedge clk);
        pulse_vld = 1'b1;
        pulse_lvl = lvl;
        pulse_us  = DUR_W'(us);
        @(negedge clk);
        pulse_vld = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] uc, input logic [7:0] db, input logic [7:0] inv,
                         input bit park, input int lead_lo, input int lead_hi,
                         input int bit_lo, input int one_hi);
        logic [31:0] w;
        w = {inv, db, uc};
        if (park) pulse(1'b1, 120000);
        pulse(1'b0, lead_lo);
        pulse(1'b1, lead_hi);
        for (int i = 0; i < 32; i++) begin
            pulse(1'b0, bit_lo);
            pulse(1'b1, w[i] ? one_hi : 560);
        end
        pulse(1'b0, 560);
    endtask

    task automatic std_frame(input logic [15:0] uc, input logic [7:0] db);
        frame(uc, db, ~db, 1'b1, 9000, 4500, 560, 1690);
    endtask

    task automatic rpt(input int gap);
        pulse(1'b1, gap);
        pulse(1'b0, 9000);
        pulse(1'b1, 2250);
        pulse(1'b0, 560);
    endtask

    // {user code, data, inverted copy, expect accepted}
    localparam logic [32:0] VEC [5] = '{
        {16'h00FF, 8'h12, 8'hED, 1'b1},
        {16'hA55A, 8'h80, 8'h7F, 1'b1},
        {16'h1234, 8'h00, 8'hFF, 1'b1},
        {16'hBEEF, 8'h3C, 8'h3C, 1'b0},
        {16'hFFFF, 8'hFF, 8'h00, 1'b1}
    };

    initial begin
        int f0, r0;
        logic [15:0] uc_prev;
        logic [7:0]  db_prev;
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 frame_vld", 32'(frame_vld), 0);
        check("R1 rpt_vld",   32'(rpt_vld),   0);
        check("R1 user_code", 32'(user_code), 0);
        check("R1 data_byte", 32'(data_byte), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {user_code, data_byte, 6'd0, frame_vld, rpt_vld}, 0);

        // R9 repeat with no prior frame
        r0 = nr;
        pulse(1'b0, 9000);
        pulse(1'b1, 2250);
        pulse(1'b0, 560);
        check("R9 no repeat from idle", nr - r0, 0);

        // table of frames: R5, R6, R7
        foreach (VEC[k]) begin
            f0 = nf;
            uc_prev = user_code;
            db_prev = data_byte;
            frame(VEC[k][32:17], VEC[k][16:9], VEC[k][8:1], 1'b1, 9000, 4500, 560, 1690);
            if (VEC[k][0]) begin
                check("R6 one strobe", nf - f0, 1);
                check("R5 user code", 32'(user_code), 32'(VEC[k][32:17]));
                check("R5 data byte", 32'(data_byte), 32'(VEC[k][16:9]));
            end else begin
                check("R7 no strobe", nf - f0, 0);
                check("R7 outputs held", {user_code, data_byte}, {uc_prev, db_prev});
            end
        end

        // R8 repeats after a good frame (both gap windows)
        std_frame(16'h4B2D, 8'h5A);
        r0 = nr;
        rpt(40000);
        check("R8 repeat short gap", nr - r0, 1);
        rpt(96000);
        check("R8 repeat long gap", nr - r0, 2);
        rpt(30000);
        check("R8 gap lower bound", nr - r0, 3);

        // R10 bad gap drops to idle
        r0 = nr;
        rpt(60000);
        check("R10 bad gap no repeat", nr - r0, 0);
        rpt(40000);
        check("R10 stays idle", nr - r0, 0);

        // R11 new frame from sequence state
        std_frame(16'h0101, 8'h11);
        f0 = nf;
        pulse(1'b1, 40000);
        frame(16'h7E81, 8'hC3, 8'h3C, 1'b0, 9000, 4500, 560, 1690);
        check("R11 frame from sequence", nf - f0, 1);
        check("R11 user code", 32'(user_code), 32'h7E81);

        // R2 leader boundaries
        f0 = nf;
        frame(16'h2222, 8'h01, 8'hFE, 1'b1, 8000, 4000, 560, 1690);
        check("R2 lower bounds accepted", nf - f0, 1);
        frame(16'h3333, 8'h02, 8'hFD, 1'b1, 10000, 5000, 560, 1690);
        check("R2 upper bounds accepted", nf - f0, 2);
        frame(16'h4444, 8'h03, 8'hFC, 1'b1, 10001, 4500, 560, 1690);
        check("R2 long leader low rejected", nf - f0, 2);
        frame(16'h5555, 8'h04, 8'hFB, 1'b1, 9000, 5001, 560, 1690);
        check("R2 long leader high rejected", nf - f0, 2);
        check("R2 code unchanged", 32'(user_code), 32'h3333);

        // R3 bit low window
        f0 = nf;
        frame(16'h6666, 8'h05, 8'hFA, 1'b1, 9000, 4500, 731, 1690);
        check("R3 bit low too long", nf - f0, 0);
        frame(16'h6667, 8'h06, 8'hF9, 1'b1, 9000, 4500, 390, 1690);
        check("R3 bit low at 390", nf - f0, 1);

        // R4 bit high windows
        f0 = nf;
        frame(16'h8001, 8'h81, 8'h7E, 1'b1, 9000, 4500, 560, 2000);
        check("R4 one at 2000", nf - f0, 1);
        check("R4 value", {user_code, data_byte}, {16'h8001, 8'h81});
        frame(16'h8001, 8'h81, 8'h7E, 1'b1, 9000, 4500, 560, 1300);
        check("R4 one at 1300", nf - f0, 2);
        frame(16'h0F0F, 8'h44, 8'hBB, 1'b1, 9000, 4500, 560, 2001);
        check("R4 one too long", nf - f0, 2);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule